// File: doc/BRIEF.md
# Return-Stack State Register with Scan

This block is the clocked heart of a state machine that can call and return from shared sub-sequences. It holds the current-state register and a small last-in, first-out stack of return states. The surrounding next-state logic stays outside the block. Each active clock edge, that logic supplies three things:
- a candidate next state;
- a select bit that picks the candidate or the stack top as the state to load;
- a stack command, which is push, pop or hold, together with the return state to store on a push.

A sub-sequence is called by pushing the state to resume at. It returns by popping while the select bit takes the stack top.

For manufacturing test, a test-mode input turns every state flop and every stack flop into one serial shift chain, with a serial input and a serial output. The active clock edge defaults to the falling edge and a parameter can change it. The state width and the stack depth are parameters, and the depth defaults to two entries. An occupancy count is exported so that stack underflow and overflow can be observed.

Top module: `rs_state_core`

## Requirements
- R1: When `rst` is high at an active edge, the current state, every stack entry and the occupancy count become zero. Zero is the initial-state encoding. Reset wins over test mode and over every other input.
- R2: A push (`cmd` = 2'b01) writes `ret_state` into the top entry (entry 0) and moves every other entry one level deeper, all on the same edge. The count rises by one.
- R3: A pop (`cmd` = 2'b10) moves each entry one level up and loads zero into the deepest entry. The count falls by one.
- R4: A hold (`cmd` = 2'b00, and also the unused code 2'b11) leaves every stack entry and the count unchanged.
- R5: With `use_top` low, the current state loads `nxt_ext`. With `use_top` high, it loads the stack top as it was before the same edge's stack update, so a pop that uses the top returns to the pushed state.
- R6: A pop while the count is zero leaves zero in the top entry and keeps the count at zero.
- R7: A push while the count equals the depth discards the deepest entry and keeps the count at the depth.
- R8: While `test_en` is high, each active edge shifts one chain of flops by one place. `scan_in` enters bit 0 of the state. Each state bit moves to the next higher bit, the state MSB feeds bit 0 of entry 0, and the MSB of entry 0 feeds bit 0 of entry 1. `scan_out` shows the MSB of the deepest entry. `cmd`, `ret_state`, `nxt_ext` and `use_top` are ignored, and the count holds.
- R9: With the default `ACT_FALL` = 1, outputs change only at falling edges of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the active edge is set by `ACT_FALL` |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Stack command: 00 hold, 01 push, 10 pop, 11 hold |
| ret_state | input | STATE_W | Return state written on a push |
| nxt_ext | input | STATE_W | Next state from external logic |
| use_top | input | 1 | 1 loads the stack top into the state, 0 loads `nxt_ext` |
| test_en | input | 1 | Scan test mode |
| scan_in | input | 1 | Serial scan input |
| scan_out | output | 1 | Serial scan output (MSB of the deepest entry) |
| cur_state | output | STATE_W | Current-state register |
| stack_top | output | STATE_W | Stack entry 0 |
| depth_cnt | output | $clog2(DEPTH+1) | Stack occupancy count |

## Verification
The assertions take for granted that `rst` is high at the first active edge, so that every stack entry deeper than the count holds zero. They also assume that `cmd`, `select` and test mode are stable from one edge to the next within a cycle. The bench drives all inputs at a point away from the active edge: right after a rising edge in most cases, and right after a falling edge in the edge-polarity test. It begins with a reset. It enters test mode only after functional state has been built up by pushes, so that every bit shifted out is a known value.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'b00,
    CMD_PUSH = 2'b01,
    CMD_POP  = 2'b10,
    CMD_RSV  = 2'b11
  } stk_cmd_t;
endpackage

// File: rtl/rs_state_reg.sv
module rs_state_reg #(
  parameter int STATE_W = 3
) (
  input  logic               aclk,
  input  logic               rst,
  input  logic               test_en,
  input  logic               sin,
  input  logic               use_top,
  input  logic [STATE_W-1:0] nxt_ext,
  input  logic [STATE_W-1:0] top_in,
  output logic [STATE_W-1:0] state,
  output logic               sout
);
  logic [STATE_W-1:0] shifted;

  generate
    if (STATE_W > 1) begin : g_wide
      assign shifted = {state[STATE_W-2:0], sin};
    end else begin : g_narrow
      assign shifted = sin;
    end
  endgenerate

  always_ff @(posedge aclk) begin
    if (rst)          state <= '0;
    else if (test_en) state <= shifted;
    else if (use_top) state <= top_in;
    else              state <= nxt_ext;
  end

  assign sout = state[STATE_W-1];

  // R5: returning via the stack top
  p_take_top_r5: assert property (@(posedge aclk) disable iff (rst)
    (!test_en && use_top) |=> state == $past(top_in));
  // R5: external next state
  p_take_ext_r5: assert property (@(posedge aclk) disable iff (rst)
    (!test_en && !use_top) |=> state == $past(nxt_ext));
  // R8: scan input lands in the state LSB
  p_scan_entry_r8: assert property (@(posedge aclk) disable iff (rst)
    test_en |=> state[0] == $past(sin));
endmodule

// File: rtl/rs_stack.sv
module rs_stack
  import rs_pkg::*;
#(
  parameter int STATE_W = 3,
  parameter int DEPTH   = 2,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic               aclk,
  input  logic               rst,
  input  logic               test_en,
  input  logic               sin,
  input  stk_cmd_t           cmd,
  input  logic [STATE_W-1:0] ret_val,
  output logic [STATE_W-1:0] top,
  output logic [CW-1:0]      cnt,
  output logic               sout
);
  localparam int NB = STATE_W * DEPTH;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [STATE_W-1:0] stk     [DEPTH];
  logic [STATE_W-1:0] stk_nxt [DEPTH];
  logic [NB-1:0]      flat;
  logic [NB-1:0]      flat_sh;
  logic [CW-1:0]      cnt_nxt;

  // pack entries, entry 0 in the low bits
  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_pack
      assign flat[gi*STATE_W +: STATE_W] = stk[gi];
    end
  endgenerate

  assign flat_sh = {flat[NB-2:0], sin};

  always_comb begin
    for (int i = 0; i < DEPTH; i++) stk_nxt[i] = stk[i];
    cnt_nxt = cnt;
    if (test_en) begin
      for (int i = 0; i < DEPTH; i++) stk_nxt[i] = flat_sh[i*STATE_W +: STATE_W];
    end else begin
      unique case (cmd)
        CMD_PUSH: begin
          stk_nxt[0] = ret_val;
          for (int i = 1; i < DEPTH; i++) stk_nxt[i] = stk[i-1];
          if (cnt != FULL) cnt_nxt = cnt + 1'b1;
        end
        CMD_POP: begin
          for (int i = 0; i < DEPTH - 1; i++) stk_nxt[i] = stk[i+1];
          stk_nxt[DEPTH-1] = '0;
          if (cnt != '0) cnt_nxt = cnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge aclk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
      cnt <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stk[i] <= stk_nxt[i];
      cnt <= cnt_nxt;
    end
  end

  assign top  = stk[0];
  assign sout = stk[DEPTH-1][STATE_W-1];

  // R2: pushed value becomes the top
  p_push_top_r2: assert property (@(posedge aclk) disable iff (rst)
    (!test_en && cmd == CMD_PUSH) |=> top == $past(ret_val));
  // R3: second entry rises to the top on pop
  p_pop_top_r3: assert property (@(posedge aclk) disable iff (rst)
    (!test_en && cmd == CMD_POP) |=> top == $past(stk[1]));
  // R4: hold keeps everything
  p_hold_r4: assert property (@(posedge aclk) disable iff (rst)
    (!test_en && (cmd == CMD_HOLD || cmd == CMD_RSV)) |=> ($stable(flat) && $stable(cnt)));
  // R6, R7: count never leaves its range
  p_no_overflow_r7: assert property (@(posedge aclk) disable iff (rst) cnt <= FULL);
  // R6: empty pop stays empty
  p_empty_pop_r6: assert property (@(posedge aclk) disable iff (rst)
    (!test_en && cmd == CMD_POP && cnt == '0) |=> (cnt == '0 && top == '0));
  // R8: count frozen during scan
  p_scan_cnt_r8: assert property (@(posedge aclk) disable iff (rst)
    test_en |=> $stable(cnt));
endmodule

// File: rtl/rs_state_core.sv
module rs_state_core
  import rs_pkg::*;
#(
  parameter int STATE_W  = 3,
  parameter int DEPTH    = 2,
  parameter bit ACT_FALL = 1'b1,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cmd,
  input  logic [STATE_W-1:0] ret_state,
  input  logic [STATE_W-1:0] nxt_ext,
  input  logic               use_top,
  input  logic               test_en,
  input  logic               scan_in,
  output logic               scan_out,
  output logic [STATE_W-1:0] cur_state,
  output logic [STATE_W-1:0] stack_top,
  output logic [CW-1:0]      depth_cnt
);
  logic aclk;
  logic link;

  generate
    if (ACT_FALL) begin : g_fall
      assign aclk = ~clk;
    end else begin : g_rise
      assign aclk = clk;
    end
  endgenerate

  rs_state_reg #(.STATE_W(STATE_W)) u_state (
    .aclk    (aclk),
    .rst     (rst),
    .test_en (test_en),
    .sin     (scan_in),
    .use_top (use_top),
    .nxt_ext (nxt_ext),
    .top_in  (stack_top),
    .state   (cur_state),
    .sout    (link)
  );

  rs_stack #(.STATE_W(STATE_W), .DEPTH(DEPTH)) u_stack (
    .aclk    (aclk),
    .rst     (rst),
    .test_en (test_en),
    .sin     (link),
    .cmd     (stk_cmd_t'(cmd)),
    .ret_val (ret_state),
    .top     (stack_top),
    .cnt     (depth_cnt),
    .sout    (scan_out)
  );

  // R1: reset clears state and occupancy
  p_reset_clear_r1: assert property (@(posedge aclk) disable iff (rst)
    $fell(rst) |-> (cur_state == '0 && depth_cnt == '0));
  // R8: state MSB feeds entry 0 during scan
  p_scan_link_r8: assert property (@(posedge aclk) disable iff (rst)
    test_en |=> stack_top[0] == $past(cur_state[STATE_W-1]));
endmodule

// File: tb/sim_rs_state_core.sv
module sim_rs_state_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmd = 2'b00;
  logic [2:0] ret_state = '0;
  logic [2:0] nxt_ext = '0;
  logic       use_top = 1'b0;
  logic       test_en = 1'b0;
  logic       scan_in = 1'b0;
  logic       scan_out;
  logic [2:0] cur_state;
  logic [2:0] stack_top;
  logic [1:0] depth_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rs_state_core u0 (
    .clk(clk), .rst(rst), .cmd(cmd), .ret_state(ret_state), .nxt_ext(nxt_ext),
    .use_top(use_top), .test_en(test_en), .scan_in(scan_in), .scan_out(scan_out),
    .cur_state(cur_state), .stack_top(stack_top), .depth_cnt(depth_cnt)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs set just after a rising edge; result read after the next rising edge
  task automatic step(logic [1:0] c, logic [2:0] r, logic [2:0] n, logic sel);
    cmd = c; ret_state = r; nxt_ext = n; use_top = sel;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(2'b01, 3'd7, 3'd7, 1'b0);
    step(2'b01, 3'd7, 3'd7, 1'b0);
    rst = 1'b0;
    chk("R1 state", cur_state, 0);
    chk("R1 top", stack_top, 0);
    chk("R1 count", depth_cnt, 0);
  endtask

  task automatic t_push_full();
    step(2'b01, 3'd3, 3'd1, 1'b0);
    chk("R2 top", stack_top, 3); chk("R2 count", depth_cnt, 1);
    chk("R5 ext state", cur_state, 1);
    step(2'b01, 3'd6, 3'd2, 1'b0);
    chk("R2 top2", stack_top, 6); chk("R2 count2", depth_cnt, 2);
    step(2'b01, 3'd5, 3'd2, 1'b0);
    chk("R7 top", stack_top, 5); chk("R7 count", depth_cnt, 2);
    step(2'b10, 3'd0, 3'd2, 1'b0);
    chk("R3 top", stack_top, 6); chk("R3 count", depth_cnt, 1);
    step(2'b10, 3'd0, 3'd2, 1'b0);
    chk("R7 bottom discarded", stack_top, 0); chk("R3 count2", depth_cnt, 0);
  endtask

  task automatic t_pop_empty();
    step(2'b10, 3'd0, 3'd3, 1'b0);
    chk("R6 top", stack_top, 0); chk("R6 count", depth_cnt, 0);
  endtask

  task automatic t_call_return();
    step(2'b01, 3'd4, 3'd2, 1'b0);
    step(2'b00, 3'd0, 3'd6, 1'b0);
    chk("R5 ext", cur_state, 6);
    step(2'b10, 3'd0, 3'd1, 1'b1);
    chk("R5 return", cur_state, 4);
    chk("R3 count after return", depth_cnt, 0);
  endtask

  task automatic t_hold();
    step(2'b01, 3'd2, 3'd0, 1'b0);
    step(2'b00, 3'd7, 3'd5, 1'b0);
    chk("R4 hold top", stack_top, 2); chk("R4 hold count", depth_cnt, 1);
    step(2'b11, 3'd7, 3'd3, 1'b0);
    chk("R4 code11 top", stack_top, 2); chk("R4 code11 count", depth_cnt, 1);
    chk("R4 state follows ext", cur_state, 3);
    step(2'b10, 3'd0, 3'd0, 1'b0);
  endtask

  task automatic t_edge();
    step(2'b00, 3'd0, 3'd1, 1'b0);
    @(negedge clk); #0.5;
    nxt_ext = 3'd7;
    @(posedge clk); #0.5;
    chk("R9 no change on rising", cur_state, 1);
    @(negedge clk); #0.5;
    chk("R9 change on falling", cur_state, 7);
    @(posedge clk); #1;
  endtask

  task automatic t_scan();
    logic [8:0] v;
    logic [8:0] pat;
    step(2'b01, 3'd3, 3'd0, 1'b0);
    step(2'b01, 3'd6, 3'd5, 1'b0);
    v = {3'd3, 3'd6, 3'd5};
    pat = 9'b101100111;
    test_en = 1'b1;
    for (int k = 0; k < 9; k++) begin
      chk("R8 scan_out", scan_out, v[8]);
      scan_in = pat[k];
      step(2'b01, 3'd7, 3'd1, 1'b1);
      v = {v[7:0], pat[k]};
    end
    chk("R8 state loaded", cur_state, v[2:0]);
    chk("R8 top loaded", stack_top, v[5:3]);
    chk("R8 count held", depth_cnt, 2);
    test_en = 1'b0;
  endtask

  initial begin
    @(posedge clk); #1;
    t_reset();
    t_push_full();
    t_pop_empty();
    t_call_return();
    t_hold();
    t_edge();
    t_scan();
    t_reset();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule